// File: doc/BRIEF.md
# Fast Ethernet receive symbol decoder

This block sits behind the analog front end of a 100 Mb/s twisted-pair or fiber receiver. It works on the recovered 125 MHz symbol clock. Each cycle it takes one symbol that has already been sliced: a three-level value in copper mode, or a plain binary bit in fiber mode. It produces 4-bit receive nibbles with a data-valid flag and an error flag, which feed a MAC receive path.

In copper mode the stream passes through three stages in order. Level changes become NRZI bits, NRZI becomes NRZ, and NRZ is descrambled. The descrambler self-synchronises to the idle stream and declares lock after a run of idle ones. Once the stream is usable, the block searches for the start-of-stream delimiter. That delimiter fixes the code-group boundaries, and every following five-bit group is decoded to a nibble. A frame ends on the end delimiter or on a premature idle. If no idle is seen for a long time, the descrambler lock is dropped. Fiber mode skips the level decoding and the descrambler, and treats the line as always usable.

Top module: `fe_rx_symbol_decoder`

## Requirements
- R1: While rstN is low and in the cycle after it is released, rxDv, rxEr, nibbleStb, scrLock and rxData are all zero.
- R2: In copper mode symIn codes a line level as 2'b00 = zero, 2'b01 = plus, 2'b11 = minus. A level different from the previous cycle's is an NRZI one. The NRZ bit is one when the NRZI bit differs from the previous NRZI bit.
- R3: In copper mode the descrambler uses the 11-stage sequence with feedback from stages 11 and 9. Until lock, it loads the inverted NRZ bits. scrLock rises on the edge that completes LOCK_ONES (default 30) consecutive descrambled ones, and never earlier.
- R4: With fiberMode high, symIn[0] is taken as the NRZI bit, with no level decoding and no descrambling. scrLock stays low and code groups are decoded at once.
- R5: Alignment is set when the last ten descrambled bits, oldest first, equal 1100010001. The delimiter produces no nibble, and rxDv first rises with the nibble of the next group.
- R6: Code groups are listed first-transmitted bit leftmost. Value 0..F maps from 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Such a group gives rxDv=1, rxEr=0 and rxData equal to the value.
- R7: Inside a frame, nibbleStb pulses for one cycle on the edge that takes in the fifth bit of each group. rxData, rxDv and rxEr change only on that edge, or when the line becomes unusable.
- R8: The end group 01101 gives rxDv=0 and rxEr=0. The following group is consumed as a tail and gives one more strobe with rxDv=0 and rxEr=0. The search then restarts.
- R9: Inside a frame, a group that is none of the above and not 11111 gives rxDv=1, rxEr=1 and rxData=0.
- R10: An idle group 11111 inside a frame ends the frame with rxDv=0 and rxEr=1 for that nibble. The tail group then clears rxEr.
- R11: While locked in copper mode, a run of IDLE_RUN (default 10) descrambled ones restarts an idle timer. After LOCK_TIMEOUT bits without such a run, scrLock falls, rxDv and rxEr clear, and alignment returns to searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered 125 MHz symbol clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fiberMode | input | 1 | 1 = binary NRZI line without scrambling |
| symIn | input | 2 | Sliced line symbol (level code, or bit 0 in fiber mode) |
| rxData | output | 4 | Decoded receive nibble |
| rxDv | output | 1 | Receive data valid |
| rxEr | output | 1 | Receive error for the current nibble |
| nibbleStb | output | 1 | One-cycle pulse when a nibble is updated |
| scrLock | output | 1 | Descrambler locked (copper mode) |

## Verification
The hardest condition to reach is the loss of lock: the line must stay locked while no idle run appears for a whole timeout window. No run of valid data groups can contain ten ones in a row. The bench therefore builds a smaller timeout into its instance and streams a long frame of repeated data groups. It checks that lock still holds partway through the window and has dropped once the window has passed. A premature idle inside a frame and an end delimiter followed by its tail are driven through a real scrambler and MLT3 model. This makes every stage of the chain take part in each decode.

// File: rtl/rxsd_pkg.sv
`timescale 1ns/1ps
package rxsd_pkg;

  typedef struct packed {
    logic freeRun;  // descrambler runs on its own feedback
    logic bypass;   // fiber line: no level decode, no descrambling
  } rxCtl_t;

  typedef enum logic [1:0] {
    ALN_SEARCH = 2'd0,
    ALN_FRAME  = 2'd1,
    ALN_TAIL   = 2'd2
  } alnState_t;

  localparam int GRP_BITS = 5;
  localparam logic [9:0] START_DELIM = 10'b11000_10001;
  localparam logic [4:0] END_GRP     = 5'b01101;
  localparam logic [4:0] IDLE_GRP    = 5'b11111;

  // returns {valid, nibble}
  function automatic logic [4:0] decodeGroup(input logic [4:0] grp);
    logic [4:0] res;
    case (grp)
      5'b11110: res = 5'h10;
      5'b01001: res = 5'h11;
      5'b10100: res = 5'h12;
      5'b10101: res = 5'h13;
      5'b01010: res = 5'h14;
      5'b01011: res = 5'h15;
      5'b01110: res = 5'h16;
      5'b01111: res = 5'h17;
      5'b10010: res = 5'h18;
      5'b10011: res = 5'h19;
      5'b10110: res = 5'h1A;
      5'b10111: res = 5'h1B;
      5'b11010: res = 5'h1C;
      5'b11011: res = 5'h1D;
      5'b11100: res = 5'h1E;
      5'b11101: res = 5'h1F;
      default:  res = 5'h00;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/rxsd_datapath.sv
`timescale 1ns/1ps
module rxsd_datapath
  import rxsd_pkg::*;
#(
  parameter int SCR_LEN = 11,
  parameter int SCR_TAP = 9,
  parameter int GRP     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        symIn,
  input  rxCtl_t            ctl,
  output logic              dBit,
  output logic [2*GRP-1:0]  shNext
);

  localparam int SH_W = 2 * GRP;

  logic [1:0]         prevSym;
  logic               prevNrzi;
  logic [SCR_LEN-1:0] lfsr;
  logic [SCR_LEN-1:0] lfsrNext;
  logic [SH_W-1:0]    sh;
  logic               nrziBit;
  logic               nrzBit;
  logic               key;

  always_comb begin
    nrziBit  = ctl.bypass ? symIn[0] : (symIn != prevSym);
    nrzBit   = nrziBit ^ prevNrzi;
    key      = lfsr[SCR_LEN-1] ^ lfsr[SCR_TAP-1];
    dBit     = ctl.bypass ? nrzBit : (nrzBit ^ key);
    shNext   = {sh[SH_W-2:0], dBit};
    if (ctl.bypass)
      lfsrNext = lfsr;
    else
      lfsrNext = {lfsr[SCR_LEN-2:0], ctl.freeRun ? key : ~nrzBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSym  <= '0;
      prevNrzi <= 1'b0;
      lfsr     <= '0;
      sh       <= '0;
    end else begin
      prevSym  <= symIn;
      prevNrzi <= nrziBit;
      lfsr     <= lfsrNext;
      sh       <= shNext;
    end
  end

  // R4: the descrambler state is frozen on a fiber line
  a_r4_lfsr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bypass |=> $stable(lfsr));

endmodule

// File: rtl/rxsd_control.sv
`timescale 1ns/1ps
module rxsd_control
  import rxsd_pkg::*;
#(
  parameter int GRP          = 5,
  parameter int LOCK_ONES    = 30,
  parameter int IDLE_RUN     = 10,
  parameter int LOCK_TIMEOUT = 16384
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fiberMode,
  input  logic             dBit,
  input  logic [2*GRP-1:0] shNext,
  output rxCtl_t           ctl,
  output logic [3:0]       rxData,
  output logic             rxDv,
  output logic             rxEr,
  output logic             nibbleStb,
  output logic             scrLock
);

  localparam int CW = $clog2(LOCK_ONES + 1);
  localparam int TW = $clog2(LOCK_TIMEOUT + 1);
  localparam int GW = $clog2(GRP);

  logic [CW-1:0] oneCnt;
  logic [CW-1:0] oneNext;
  logic [TW-1:0] idleTmr;
  logic          linkUp;
  logic          lockDrop;
  logic          idleRun;
  logic [GW-1:0] bitCnt;
  logic          grpDone;
  logic [4:0]    grp;
  logic [4:0]    decoded;
  alnState_t     state;

  always_comb begin
    if (!dBit)                          oneNext = '0;
    else if (oneCnt == CW'(LOCK_ONES))  oneNext = oneCnt;
    else                                oneNext = oneCnt + 1'b1;
    idleRun  = (oneNext >= CW'(IDLE_RUN));
    linkUp   = fiberMode | scrLock;
    lockDrop = !fiberMode && scrLock && !idleRun &&
               (idleTmr == TW'(LOCK_TIMEOUT - 1));
    grpDone  = (bitCnt == GW'(GRP - 1));
    grp      = shNext[4:0];
    decoded  = decodeGroup(grp);
    ctl.bypass  = fiberMode;
    ctl.freeRun = scrLock;
  end

  // descrambler lock and idle timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oneCnt  <= '0;
      idleTmr <= '0;
      scrLock <= 1'b0;
    end else if (fiberMode) begin
      oneCnt  <= oneNext;
      idleTmr <= '0;
      scrLock <= 1'b0;
    end else if (!scrLock) begin
      oneCnt  <= oneNext;
      idleTmr <= '0;
      if (oneNext == CW'(LOCK_ONES)) scrLock <= 1'b1;
    end else if (idleRun) begin
      oneCnt  <= oneNext;
      idleTmr <= '0;
    end else if (lockDrop) begin
      oneCnt  <= '0;
      idleTmr <= '0;
      scrLock <= 1'b0;
    end else begin
      oneCnt  <= oneNext;
      idleTmr <= idleTmr + 1'b1;
    end
  end

  // code-group alignment and nibble output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ALN_SEARCH;
      bitCnt    <= '0;
      rxData    <= '0;
      rxDv      <= 1'b0;
      rxEr      <= 1'b0;
      nibbleStb <= 1'b0;
    end else if (!linkUp || lockDrop) begin
      state     <= ALN_SEARCH;
      bitCnt    <= '0;
      rxData    <= '0;
      rxDv      <= 1'b0;
      rxEr      <= 1'b0;
      nibbleStb <= 1'b0;
    end else begin
      nibbleStb <= 1'b0;
      case (state)
        ALN_SEARCH: begin
          if (shNext == START_DELIM) begin
            state  <= ALN_FRAME;
            bitCnt <= '0;
          end
        end
        ALN_FRAME: begin
          if (!grpDone) begin
            bitCnt <= bitCnt + 1'b1;
          end else begin
            bitCnt    <= '0;
            nibbleStb <= 1'b1;
            if (grp == END_GRP) begin
              rxData <= '0;
              rxDv   <= 1'b0;
              rxEr   <= 1'b0;
              state  <= ALN_TAIL;
            end else if (grp == IDLE_GRP) begin
              rxData <= '0;
              rxDv   <= 1'b0;
              rxEr   <= 1'b1;
              state  <= ALN_TAIL;
            end else begin
              rxData <= decoded[4] ? decoded[3:0] : 4'h0;
              rxDv   <= 1'b1;
              rxEr   <= !decoded[4];
            end
          end
        end
        default: begin
          if (!grpDone) begin
            bitCnt <= bitCnt + 1'b1;
          end else begin
            bitCnt    <= '0;
            nibbleStb <= 1'b1;
            rxData    <= '0;
            rxDv      <= 1'b0;
            rxEr      <= 1'b0;
            state     <= ALN_SEARCH;
          end
        end
      endcase
    end
  end

  // R3: lock is declared only after the full run of ones
  a_r3_lock_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scrLock) |-> $past(oneCnt) == CW'(LOCK_ONES - 1));

  // R11: the idle timer never passes its limit while locked
  a_r11_timer_bound: assert property (@(posedge clk) disable iff (!rstN)
    scrLock |-> idleTmr < TW'(LOCK_TIMEOUT));

  // R7: strobes are single-cycle pulses
  a_r7_stb_pulse: assert property (@(posedge clk) disable iff (!rstN)
    nibbleStb |=> !nibbleStb);

  // R7: outputs hold between strobes while the line is usable
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!nibbleStb && linkUp) |-> $stable({rxData, rxDv, rxEr}));

  // R9: an errored valid nibble carries zero data
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rxDv && rxEr) |-> rxData == 4'h0);

  // R5: data valid only on a usable line
  a_r5_dv_link: assert property (@(posedge clk) disable iff (!rstN)
    rxDv |-> linkUp);

endmodule

// File: rtl/fe_rx_symbol_decoder.sv
`timescale 1ns/1ps
module fe_rx_symbol_decoder
  import rxsd_pkg::*;
#(
  parameter int SCR_LEN      = 11,
  parameter int SCR_TAP      = 9,
  parameter int LOCK_ONES    = 30,
  parameter int IDLE_RUN     = 10,
  parameter int LOCK_TIMEOUT = 16384
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fiberMode,
  input  logic [1:0] symIn,
  output logic [3:0] rxData,
  output logic       rxDv,
  output logic       rxEr,
  output logic       nibbleStb,
  output logic       scrLock
);

  localparam int SH_W = 2 * GRP_BITS;

  rxCtl_t          ctl;
  logic            dBit;
  logic [SH_W-1:0] shNext;

  rxsd_datapath #(
    .SCR_LEN (SCR_LEN),
    .SCR_TAP (SCR_TAP),
    .GRP     (GRP_BITS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .symIn  (symIn),
    .ctl    (ctl),
    .dBit   (dBit),
    .shNext (shNext)
  );

  rxsd_control #(
    .GRP          (GRP_BITS),
    .LOCK_ONES    (LOCK_ONES),
    .IDLE_RUN     (IDLE_RUN),
    .LOCK_TIMEOUT (LOCK_TIMEOUT)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .fiberMode (fiberMode),
    .dBit      (dBit),
    .shNext    (shNext),
    .ctl       (ctl),
    .rxData    (rxData),
    .rxDv      (rxDv),
    .rxEr      (rxEr),
    .nibbleStb (nibbleStb),
    .scrLock   (scrLock)
  );

endmodule

// File: tb/tb_fe_rx_symbol_decoder.sv
`timescale 1ns/1ps
module tb_fe_rx_symbol_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fiberMode = 1'b0;
  logic [1:0] symIn = 2'b00;
  logic [3:0] rxData;
  logic       rxDv, rxEr, nibbleStb, scrLock;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  fe_rx_symbol_decoder #(.LOCK_TIMEOUT(200)) dut (
    .clk(clk), .rstN(rstN), .fiberMode(fiberMode), .symIn(symIn),
    .rxData(rxData), .rxDv(rxDv), .rxEr(rxEr),
    .nibbleStb(nibbleStb), .scrLock(scrLock)
  );

  always #2.5 clk = ~clk;

  // transmit-side model
  logic [10:0] txScr = 11'h5A3;
  logic        txNrzi = 1'b0;
  logic [1:0]  txPhase = 2'd0;
  logic        cStb, cDv, cEr, cLock;
  logic [3:0]  cData;
  int          earlyStb;

  // {code, expData, expDv, expEr}
  localparam int NV = 20;
  localparam logic [10:0] VEC [0:NV-1] = '{
    {5'b11110, 4'h0, 1'b1, 1'b0}, {5'b01001, 4'h1, 1'b1, 1'b0},
    {5'b10100, 4'h2, 1'b1, 1'b0}, {5'b10101, 4'h3, 1'b1, 1'b0},
    {5'b01010, 4'h4, 1'b1, 1'b0}, {5'b01011, 4'h5, 1'b1, 1'b0},
    {5'b01110, 4'h6, 1'b1, 1'b0}, {5'b01111, 4'h7, 1'b1, 1'b0},
    {5'b10010, 4'h8, 1'b1, 1'b0}, {5'b10011, 4'h9, 1'b1, 1'b0},
    {5'b10110, 4'hA, 1'b1, 1'b0}, {5'b10111, 4'hB, 1'b1, 1'b0},
    {5'b11010, 4'hC, 1'b1, 1'b0}, {5'b11011, 4'hD, 1'b1, 1'b0},
    {5'b11100, 4'hE, 1'b1, 1'b0}, {5'b11101, 4'hF, 1'b1, 1'b0},
    {5'b00000, 4'h0, 1'b1, 1'b1}, {5'b11000, 4'h0, 1'b1, 1'b1},
    {5'b01011, 4'h5, 1'b1, 1'b0}, {5'b01101, 4'h0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    logic s, k;
    if (!fiberMode) begin
      k = txScr[10] ^ txScr[8];
      txScr = {txScr[9:0], k};
      s = b ^ k;
    end else begin
      s = b;
    end
    txNrzi = txNrzi ^ s;
    if (!fiberMode && txNrzi) txPhase = txPhase + 2'd1;
    @(negedge clk);
    if (fiberMode) symIn = {1'b0, txNrzi};
    else case (txPhase)
      2'd1:    symIn = 2'b01;
      2'd3:    symIn = 2'b11;
      default: symIn = 2'b00;
    endcase
    @(posedge clk);
    #1;
    cStb = nibbleStb; cDv = rxDv; cEr = rxEr; cData = rxData; cLock = scrLock;
  endtask

  task automatic sendGroup(input logic [4:0] code);
    earlyStb = 0;
    for (int i = 4; i >= 0; i--) begin
      sendBit(code[i]);
      if (i > 0 && cStb) earlyStb++;
    end
  endtask

  task automatic sendIdle(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic sendDelim();
    int seen;
    seen = 0;
    sendGroup(5'b11000); seen += earlyStb + int'(cStb);
    sendGroup(5'b10001); seen += earlyStb + int'(cStb);
    chk("R5 no strobe during delimiter", seen, 0);
    chk("R5 dv low after delimiter", cDv, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 dv in reset", rxDv, 0);
    chk("R1 lock in reset", scrLock, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 stb after reset", nibbleStb, 0);
    chk("R1 er after reset", rxEr, 0);
    chk("R1 data after reset", rxData, 0);

    // R3: lock acquisition on scrambled idle
    sendIdle(20);
    chk("R3 no lock after 20 idle bits", cLock, 0);
    sendIdle(40);
    chk("R3 lock after 60 idle bits", cLock, 1);
    sendIdle(10);

    // frame 1: full table through MLT3, NRZI and descrambler (R2, R6, R7, R8, R9)
    sendDelim();
    for (int i = 0; i < NV; i++) begin
      sendGroup(VEC[i][10:6]);
      chk("R7 strobe on fifth bit", cStb, 1);
      chk("R7 no strobe on bits 1-4", earlyStb, 0);
      chk("R2 R6 decoded nibble", cData, VEC[i][5:2]);
      chk("R6 R8 data valid", cDv, VEC[i][1]);
      chk("R9 error flag", cEr, VEC[i][0]);
    end
    sendGroup(5'b00111);  // tail after end group
    chk("R8 tail strobe", cStb, 1);
    chk("R8 tail dv", cDv, 0);
    chk("R8 tail er", cEr, 0);
    sendIdle(20);
    chk("R8 search again, no strobe", cStb, 0);

    // frame 2: premature idle (R10)
    sendDelim();
    sendGroup(5'b01011);
    chk("R10 pre data", cData, 5);
    chk("R10 pre dv", cDv, 1);
    sendGroup(5'b11111);
    chk("R10 idle strobe", cStb, 1);
    chk("R10 idle dv", cDv, 0);
    chk("R10 idle er", cEr, 1);
    sendGroup(5'b11111);
    chk("R10 tail clears er", cEr, 0);
    chk("R10 tail strobe", cStb, 1);
    sendIdle(20);

    // frame 3: no idle for longer than the timeout (R11)
    sendDelim();
    for (int i = 0; i < 30; i++) sendGroup(5'b01011);
    chk("R11 lock held inside window", cLock, 1);
    chk("R11 dv inside window", cDv, 1);
    for (int i = 0; i < 15; i++) sendGroup(5'b01011);
    chk("R11 lock lost after window", cLock, 0);
    chk("R11 dv cleared after loss", cDv, 0);
    chk("R11 er cleared after loss", cEr, 0);

    // fiber mode (R4)
    @(negedge clk);
    rstN = 1'b0; fiberMode = 1'b1; symIn = 2'b00;
    txNrzi = 1'b0; txPhase = 2'd0;
    @(negedge clk); rstN = 1'b1;
    sendIdle(20);
    sendDelim();
    sendGroup(5'b10101);
    chk("R4 fiber data 3", cData, 3);
    chk("R4 fiber dv", cDv, 1);
    sendGroup(5'b10110);
    chk("R4 fiber data A", cData, 10);
    chk("R4 fiber no lock flag", cLock, 0);
    sendGroup(5'b01101);
    chk("R4 R8 fiber end dv", cDv, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule